// File: doc/BRIEF.md
# Message-Signalled Interrupt Target Address Composer

This block turns an interrupt delivery request into the address and data of a single message-signalled interrupt write. A request carries a hart index, a guest index and an external interrupt identity. The block splits the hart index into a group part and a hart-within-group part. It places each part, and the guest index, at bit positions that software programs into a pair of configuration registers. The base page number held in those registers forms the rest of the target page.

A second entry point lets software send one message directly. Its single 32-bit word carries the hart index and the identity, and it always uses guest index 0. The block is built either for a machine-level domain or for a supervisor-level domain. A machine-level build forces the guest index to 0 for every message.

The composed pair is registered and presented on a valid/ready handshake. The bus write that follows lies outside the block.

Top module: `msi_target_composer`

## Requirements
- R1: After reset both configuration registers read 0, `msg_valid` is 0, and `req_ready` and `sw_ready` are 1.
- R2: A write to the low configuration register stores all 32 bits. A write to the high register stores the written value ANDed with 0x9F77FFFF, so only its defined fields are kept.
- R3: While bit 31 (lock) of the high register is 1, writes to either configuration register leave both unchanged.
- R4: The hart index is split by the width field in high bits 15:12 (LW). The group index is the hart index shifted right by LW. The hart-within-group index is the low LW bits of the hart index.
- R5: The page number is the OR of four terms. The first is the base: high bits 11:0 above low bits 31:0. The second is the group index masked to the width in high bits 18:16 and shifted left by (high bits 28:24) + 12. The third is the hart-within-group index shifted left by high bits 22:20 (LS). The fourth is the guest index masked to LS bits.
- R6: `msg_addr` is the page number shifted left by 12. `msg_data` is the interrupt identity zero-extended to 32 bits.
- R7: A build with MACHINE_LEVEL=1 uses guest index 0 for every message, whatever `req_guest` holds.
- R8: A software send takes the hart index from `sw_data` bits 31:18 and the identity from bits 10:0, and uses guest index 0. When it is offered in the same cycle as a request, the software send is taken first and `req_ready` is 0.
- R9: A message appears on `msg_valid` in the cycle after it is accepted. It stays valid with stable address and data until `msg_ready`. While it waits, `req_ready` and `sw_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_hi | input | 1 | Selects the high (1) or low (0) configuration register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_lo_o | output | 32 | Current low configuration register |
| cfg_hi_o | output | 32 | Current high configuration register |
| req_valid | input | 1 | Delivery request offered |
| req_ready | output | 1 | Delivery request accepted this cycle when valid |
| req_hart | input | HART_W | Target hart index |
| req_guest | input | GUEST_W | Target guest index |
| req_eiid | input | EIID_W | External interrupt identity |
| sw_valid | input | 1 | Software send offered |
| sw_ready | output | 1 | Software send accepted this cycle when valid |
| sw_data | input | 32 | Software send word |
| msg_valid | output | 1 | Composed message available |
| msg_ready | input | 1 | Downstream takes the message |
| msg_addr | output | ADDR_W | Byte address of the message write |
| msg_data | output | 32 | Data word of the message write |

## Verification
The bench builds two copies side by side on shared stimulus. Both use the default widths: a 14-bit hart index, a 6-bit guest index, an 11-bit identity and a 64-bit address. One copy is supervisor-level and the other machine-level. The pairing puts the forced-zero guest path against the masked guest path for the same configuration and request. The full 14-bit hart and the 5-bit group shift reach address bits up to 61, so the high base bits and the largest group positions can be observed.

// File: rtl/msi_comp_pkg.sv
package msi_comp_pkg;

   // High configuration register; the field positions are decoded by the
   // address composer and are part of the software contract.
   typedef struct packed {
      logic       lock;       // 31
      logic [1:0] rsv_a;      // 30:29
      logic [4:0] grp_shift;  // 28:24
      logic       rsv_b;      // 23
      logic [2:0] hart_shift; // 22:20
      logic       rsv_c;      // 19
      logic [2:0] grp_width;  // 18:16
      logic [3:0] hart_width; // 15:12
      logic [11:0] base_hi;   // 11:0
   } cfg_hi_t;

   localparam logic [31:0] HI_WRITE_MASK = 32'h9F77_FFFF;
   localparam int BASE_HI_W   = 12;
   localparam int MAX_GRP_W   = 7;
   localparam int MAX_GRP_SHF = 31;

endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
   import msi_comp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic        cfg_sel_hi,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_lo,
   output cfg_hi_t     cfg_hi
);

   logic wr_open;

   assign wr_open = cfg_we & ~cfg_hi.lock;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_lo <= '0;
         cfg_hi <= '0;
      end else if (wr_open) begin
         if (cfg_sel_hi) begin
            cfg_hi <= cfg_hi_t'(cfg_wdata & HI_WRITE_MASK);
         end else begin
            cfg_lo <= cfg_wdata;
         end
      end
   end

endmodule

// File: rtl/msi_addr_calc.sv
module msi_addr_calc
   import msi_comp_pkg::*;
#(
   parameter int HART_W        = 14,
   parameter int GUEST_W       = 6,
   parameter int EIID_W        = 11,
   parameter int ADDR_W        = 64,
   parameter int PAGE_SHIFT    = 12,
   parameter bit MACHINE_LEVEL = 1'b0
) (
   input  logic [31:0]        cfg_lo,
   input  cfg_hi_t            cfg_hi,
   input  logic [HART_W-1:0]  hart,
   input  logic [GUEST_W-1:0] guest,
   input  logic [EIID_W-1:0]  eiid,
   output logic [ADDR_W-1:0]  addr,
   output logic [31:0]        data
);

   localparam int PPN_W = ADDR_W - PAGE_SHIFT;

   logic [GUEST_W-1:0] guest_eff;
   logic [HART_W-1:0]  grp_full;
   logic [HART_W-1:0]  grp_mask;
   logic [HART_W-1:0]  wig_mask;
   logic [GUEST_W-1:0] gst_mask;
   logic [PPN_W-1:0]   base_t;
   logic [PPN_W-1:0]   grp_t;
   logic [PPN_W-1:0]   wig_t;
   logic [PPN_W-1:0]   gst_t;
   logic [PPN_W-1:0]   ppn;

   generate
      if (MACHINE_LEVEL) begin : g_mlevel
         logic unused_guest;
         assign unused_guest = ^guest;
         assign guest_eff    = '0;
      end else begin : g_slevel
         assign guest_eff = guest;
      end
   endgenerate

   always_comb begin
      grp_full = hart >> cfg_hi.hart_width;
      grp_mask = ~({HART_W{1'b1}} << cfg_hi.grp_width);
      wig_mask = ~({HART_W{1'b1}} << cfg_hi.hart_width);
      gst_mask = ~({GUEST_W{1'b1}} << cfg_hi.hart_shift);
      base_t   = PPN_W'({cfg_hi.base_hi, cfg_lo});
      grp_t    = PPN_W'(grp_full & grp_mask) << (int'(cfg_hi.grp_shift) + PAGE_SHIFT);
      wig_t    = PPN_W'(hart & wig_mask) << cfg_hi.hart_shift;
      gst_t    = PPN_W'(guest_eff & gst_mask);
      ppn      = base_t | grp_t | wig_t | gst_t;
   end

   assign addr = {ppn, {PAGE_SHIFT{1'b0}}};
   assign data = 32'(eiid);

   logic unused_hi;
   assign unused_hi = ^{cfg_hi.lock, cfg_hi.rsv_a, cfg_hi.rsv_b, cfg_hi.rsv_c};

endmodule

// File: rtl/msi_out_stage.sv
module msi_out_stage #(
   parameter int ADDR_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [31:0]       data_in,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic [31:0]       out_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_data  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_addr  <= addr_in;
         out_data  <= data_in;
      end else if (out_valid && out_ready) begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/msi_target_composer.sv
module msi_target_composer
   import msi_comp_pkg::*;
#(
   parameter int HART_W        = 14,
   parameter int GUEST_W       = 6,
   parameter int EIID_W        = 11,
   parameter int ADDR_W        = 64,
   parameter int PAGE_SHIFT    = 12,
   parameter bit MACHINE_LEVEL = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic               cfg_sel_hi,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_lo_o,
   output logic [31:0]        cfg_hi_o,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [HART_W-1:0]  req_hart,
   input  logic [GUEST_W-1:0] req_guest,
   input  logic [EIID_W-1:0]  req_eiid,
   input  logic               sw_valid,
   output logic               sw_ready,
   input  logic [31:0]        sw_data,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [ADDR_W-1:0]  msg_addr,
   output logic [31:0]        msg_data
);

   localparam int PPN_W       = ADDR_W - PAGE_SHIFT;
   localparam int SW_HART_LSB = 18;

   generate
      if (HART_W < 1 || HART_W > 32 - SW_HART_LSB) begin : g_bad_hart
         $error("HART_W must fit the software send field");
      end
      if (EIID_W < 1 || EIID_W > 12) begin : g_bad_eiid
         $error("EIID_W must be 1..12");
      end
      if (GUEST_W < 1 || GUEST_W > 8) begin : g_bad_guest
         $error("GUEST_W must be 1..8");
      end
      if (PPN_W < 32 + BASE_HI_W ||
          PPN_W < MAX_GRP_SHF + PAGE_SHIFT + MAX_GRP_W) begin : g_bad_addr
         $error("ADDR_W too small for the page number");
      end
   endgenerate

   cfg_hi_t            cfg_hi;
   logic [31:0]        cfg_lo;
   logic               sw_take;
   logic               req_take;
   logic [HART_W-1:0]  sel_hart;
   logic [GUEST_W-1:0] sel_guest;
   logic [EIID_W-1:0]  sel_eiid;
   logic [ADDR_W-1:0]  cmp_addr;
   logic [31:0]        cmp_data;

   msi_cfg_regs u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel_hi (cfg_sel_hi),
      .cfg_wdata  (cfg_wdata),
      .cfg_lo     (cfg_lo),
      .cfg_hi     (cfg_hi)
   );

   assign cfg_lo_o = cfg_lo;
   assign cfg_hi_o = cfg_hi;

   // Software send has precedence; one message in flight at a time.
   assign sw_ready  = ~msg_valid;
   assign req_ready = ~msg_valid & ~sw_valid;
   assign sw_take   = sw_valid & sw_ready;
   assign req_take  = req_valid & req_ready;

   always_comb begin
      if (sw_take) begin
         sel_hart  = sw_data[SW_HART_LSB +: HART_W];
         sel_guest = '0;
         sel_eiid  = sw_data[EIID_W-1:0];
      end else begin
         sel_hart  = req_hart;
         sel_guest = req_guest;
         sel_eiid  = req_eiid;
      end
   end

   msi_addr_calc #(
      .HART_W        (HART_W),
      .GUEST_W       (GUEST_W),
      .EIID_W        (EIID_W),
      .ADDR_W        (ADDR_W),
      .PAGE_SHIFT    (PAGE_SHIFT),
      .MACHINE_LEVEL (MACHINE_LEVEL)
   ) u_calc (
      .cfg_lo (cfg_lo),
      .cfg_hi (cfg_hi),
      .hart   (sel_hart),
      .guest  (sel_guest),
      .eiid   (sel_eiid),
      .addr   (cmp_addr),
      .data   (cmp_data)
   );

   msi_out_stage #(
      .ADDR_W (ADDR_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sw_take | req_take),
      .addr_in   (cmp_addr),
      .data_in   (cmp_data),
      .out_ready (msg_ready),
      .out_valid (msg_valid),
      .out_addr  (msg_addr),
      .out_data  (msg_data)
   );

   logic unused_sw;
   assign unused_sw = ^sw_data[SW_HART_LSB-1:EIID_W];

endmodule

// File: rtl/msi_target_composer_chk.sv
module msi_target_composer_chk
   import msi_comp_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int EIID_W     = 11,
   parameter int PAGE_SHIFT = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [31:0]       cfg_lo_o,
   input logic [31:0]       cfg_hi_o,
   input logic              req_valid,
   input logic              req_ready,
   input logic              sw_valid,
   input logic              sw_ready,
   input logic              msg_valid,
   input logic              msg_ready,
   input logic [ADDR_W-1:0] msg_addr,
   input logic [31:0]       msg_data
);

   p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hi_o & ~HI_WRITE_MASK) == 32'h0);

   p_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hi_o[31] |=> $stable(cfg_hi_o) && $stable(cfg_lo_o));

   p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_addr[PAGE_SHIFT-1:0] == '0) && (msg_data[31:EIID_W] == '0));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

   p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !req_ready && !sw_ready);

   p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_valid |-> !req_ready);

   p_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> $past((req_valid && req_ready) || (sw_valid && sw_ready)));

endmodule

bind msi_target_composer msi_target_composer_chk #(
   .ADDR_W     (ADDR_W),
   .EIID_W     (EIID_W),
   .PAGE_SHIFT (PAGE_SHIFT)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_lo_o  (cfg_lo_o),
   .cfg_hi_o  (cfg_hi_o),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .sw_valid  (sw_valid),
   .sw_ready  (sw_ready),
   .msg_valid (msg_valid),
   .msg_ready (msg_ready),
   .msg_addr  (msg_addr),
   .msg_data  (msg_data)
);

// File: tb/msi_target_composer_tb.sv
module msi_target_composer_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel_hi = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [13:0] req_hart = '0;
   logic [5:0]  req_guest = '0;
   logic [10:0] req_eiid = '0;
   logic        sw_valid = 1'b0;
   logic [31:0] sw_data = '0;
   logic        msg_ready = 1'b1;

   logic [31:0] s_lo, s_hi, m_lo, m_hi;
   logic        s_req_rdy, s_sw_rdy, s_vld, m_req_rdy, m_sw_rdy, m_vld;
   logic [63:0] s_addr, m_addr;
   logic [31:0] s_data, m_data;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_target_composer #(.MACHINE_LEVEL(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel_hi(cfg_sel_hi),
      .cfg_wdata(cfg_wdata), .cfg_lo_o(s_lo), .cfg_hi_o(s_hi),
      .req_valid(req_valid), .req_ready(s_req_rdy), .req_hart(req_hart),
      .req_guest(req_guest), .req_eiid(req_eiid), .sw_valid(sw_valid),
      .sw_ready(s_sw_rdy), .sw_data(sw_data), .msg_valid(s_vld),
      .msg_ready(msg_ready), .msg_addr(s_addr), .msg_data(s_data));

   msi_target_composer #(.MACHINE_LEVEL(1'b1)) dut_m_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel_hi(cfg_sel_hi),
      .cfg_wdata(cfg_wdata), .cfg_lo_o(m_lo), .cfg_hi_o(m_hi),
      .req_valid(req_valid), .req_ready(m_req_rdy), .req_hart(req_hart),
      .req_guest(req_guest), .req_eiid(req_eiid), .sw_valid(sw_valid),
      .sw_ready(m_sw_rdy), .sw_data(sw_data), .msg_valid(m_vld),
      .msg_ready(msg_ready), .msg_addr(m_addr), .msg_data(m_data));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Independent model of the page composition, written with arithmetic.
   function automatic logic [63:0] model_addr(input logic [31:0] lo, input logic [31:0] hi,
                                               input logic [13:0] hart, input logic [5:0] guest);
      int lw = int'(hi[15:12]);
      int hw = int'(hi[18:16]);
      int ls = int'(hi[22:20]);
      int hs = int'(hi[28:24]);
      logic [63:0] grp, wig, gst, ppn;
      grp = (64'(hart) >> lw) % (64'd1 << hw);
      wig = 64'(hart) % (64'd1 << lw);
      gst = 64'(guest) % (64'd1 << ls);
      ppn = {20'd0, hi[11:0], lo} | (grp << (hs + 12)) | (wig << ls) | gst;
      return ppn << 12;
   endfunction

   task automatic write_cfg(input bit hi, input logic [31:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel_hi = hi; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Offers a request; returns at the negedge after acceptance.
   task automatic send_req(input logic [13:0] h, input logic [5:0] g, input logic [10:0] e);
      @(negedge clk);
      req_valid = 1'b1; req_hart = h; req_guest = g; req_eiid = e;
      while (!s_req_rdy) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_msg(input string tag, input logic [13:0] h, input logic [5:0] g,
                             input logic [10:0] e);
      check({tag, " s valid"}, 64'(s_vld), 64'd1);
      check({tag, " s addr"}, s_addr, model_addr(s_lo, s_hi, h, g));
      check({tag, " s data"}, 64'(s_data), 64'(e));
      check({tag, " m addr (R7 guest 0)"}, m_addr, model_addr(m_lo, m_hi, h, 6'd0));
   endtask

   task automatic t_reset();
      check("R1 lo", 64'(s_lo), 64'd0);
      check("R1 hi", 64'(s_hi), 64'd0);
      check("R1 valid", 64'(s_vld), 64'd0);
      check("R1 req_ready", 64'(s_req_rdy), 64'd1);
      check("R1 sw_ready", 64'(s_sw_rdy), 64'd1);
   endtask

   task automatic t_mask();
      write_cfg(1'b1, 32'h7FFF_FFFF);
      check("R2 hi masked", 64'(s_hi), 64'h1F77_FFFF);
      write_cfg(1'b0, 32'hDEAD_BEEF);
      check("R2 lo full", 64'(s_lo), 64'hDEAD_BEEF);
      write_cfg(1'b1, 32'hFFFF_0000 & 32'h7FFF_FFFF);
      check("R2 hi rewrite", 64'(s_hi), 64'h1F77_0000);
   endtask

   task automatic t_flat();
      write_cfg(1'b1, 32'h0);
      write_cfg(1'b0, 32'h0001_0000);
      send_req(14'h3A5, 6'd7, 11'h123);
      check("R6 flat addr", s_addr, 64'h0000_0000_1000_0000);
      check("R6 flat data", 64'(s_data), 64'h123);
      check("R4 flat group dropped", m_addr, 64'h0000_0000_1000_0000);
   endtask

   task automatic t_geom();
      // grp_shift 4, hart_shift 3, grp_width 2, hart_width 2, base_hi 1
      write_cfg(1'b1, 32'h0432_2001);
      write_cfg(1'b0, 32'h0);
      send_req(14'd13, 6'd5, 11'h7FF);
      check("R5 geom addr", s_addr, 64'h0000_1000_3000_D000);
      check("R4 geom split", s_addr, model_addr(32'h0, 32'h0432_2001, 14'd13, 6'd5));
      check("R7 machine guest 0", m_addr, 64'h0000_1000_3000_8000);
      check("R6 max eiid", 64'(s_data), 64'h7FF);
   endtask

   task automatic t_sweep();
      logic [31:0] seed = 32'h1234_5678;
      for (int c = 0; c < 6; c++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         write_cfg(1'b1, seed & 32'h1F77_FFFF);
         seed = seed * 32'd1664525 + 32'd1013904223;
         write_cfg(1'b0, seed);
         for (int k = 0; k < 8; k++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            send_req(seed[31:18], seed[17:12], seed[10:0]);
            expect_msg("R5 sweep", seed[31:18], seed[17:12], seed[10:0]);
         end
      end
   endtask

   task automatic t_stall();
      logic [63:0] held;
      write_cfg(1'b1, 32'h0513_1002);
      write_cfg(1'b0, 32'h00AB_C000);
      @(negedge clk);
      msg_ready = 1'b0;
      send_req(14'h1234, 6'h2A, 11'h055);
      held = s_addr;
      expect_msg("R9 first", 14'h1234, 6'h2A, 11'h055);
      req_valid = 1'b1; req_hart = 14'h0007; req_guest = 6'h01; req_eiid = 11'h066;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R9 held valid", 64'(s_vld), 64'd1);
         check("R9 held addr", s_addr, held);
         check("R9 req_ready low", 64'(s_req_rdy), 64'd0);
         check("R9 sw_ready low", 64'(s_sw_rdy), 64'd0);
      end
      msg_ready = 1'b1;
      @(negedge clk);
      check("R9 drained", 64'(s_vld), 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      expect_msg("R9 second", 14'h0007, 6'h01, 11'h066);
   endtask

   task automatic t_swgen();
      write_cfg(1'b1, 32'h0322_3005);
      write_cfg(1'b0, 32'h0000_4000);
      @(negedge clk);
      sw_valid = 1'b1;
      sw_data  = {14'h2ABC, 6'h3F, 1'b1, 11'h3C1};
      @(negedge clk);
      sw_valid = 1'b0;
      check("R8 sw addr guest 0", s_addr, model_addr(s_lo, s_hi, 14'h2ABC, 6'd0));
      check("R8 sw data", 64'(s_data), 64'h3C1);
   endtask

   task automatic t_prio();
      @(negedge clk);
      sw_valid = 1'b1; sw_data = {14'h0011, 18'h00022};
      req_valid = 1'b1; req_hart = 14'h0033; req_guest = 6'h3; req_eiid = 11'h044;
      #1;
      check("R8 req_ready low with sw", 64'(s_req_rdy), 64'd0);
      @(negedge clk);
      sw_valid = 1'b0;
      check("R8 sw first", 64'(s_data), 64'h022);
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      expect_msg("R8 req second", 14'h0033, 6'h3, 11'h044);
   endtask

   task automatic t_lock();
      write_cfg(1'b1, 32'h8222_1003);
      check("R3 lock set", 64'(s_hi), 64'h8222_1003);
      write_cfg(1'b0, 32'h5555_5555);
      write_cfg(1'b1, 32'h0000_0000);
      check("R3 lo unchanged", 64'(s_lo), 64'h0000_4000);
      check("R3 hi unchanged", 64'(s_hi), 64'h8222_1003);
      send_req(14'h0F0F, 6'h15, 11'h100);
      expect_msg("R3 locked cfg used", 14'h0F0F, 6'h15, 11'h100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_flat();
      t_geom();
      t_sweep();
      t_stall();
      t_swgen();
      t_prio();
      t_lock();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule